// File: doc/BRIEF.md
# RMAP Command Packet Validator

This block sits on the byte stream that feeds the configuration port of a packet router. It inspects each incoming remote memory access command as it arrives and checks the header fields and the lengths. It also checks the two CRC-8 check bytes and the way the packet is terminated. A packet that passes every check gives a one-cycle `pkt_good` pulse. A packet that fails records the first fault it shows in a sticky 14-bit status word. After that fault the rest of the packet is dropped up to its end marker. Software reads the status word and clears individual bits by writing ones.

The stream carries one character per `in_valid` cycle. A character is either a data byte (`in_ctrl`=0) or an end marker (`in_ctrl`=1). For an end marker, `in_data[0]` selects normal end (0) or error end (1). The header is 16 bytes, in this order: target logical address, protocol id, instruction, key, initiator address, two transaction-id bytes, extended address, four address bytes, three length bytes (most significant first), and the header CRC. The command code is instruction bits [5:2]. Bit 5 means write, bit 4 verify, bit 3 reply and bit 2 increment. Bits [1:0] give the reply-address length. Write commands (code bit 3 set) and read-modify-write (code 0111) carry the data bytes and then a data CRC. Other commands end right after the header CRC.

Top module: `rmap_cmd_validator`

## Requirements
- R1: After reset every status bit is 0. Status bit 0 is always the OR of bits 13 to 1.
- R2: A first byte other than TARGET_LA (254) sets bit 8.
- R3: A key byte (byte 3) other than DEST_KEY sets bit 4.
- R4: Bit 5 is set when the command code indexes a 0 in CMD_MASK (default: only codes 2, 3, 7 and 8 to 15 are accepted), or when the reply-address length field is non-zero.
- R5: The CRC is bit-reflected CRC-8 with polynomial x^8+x^2+x+1, initial value 0, each byte folded in least significant bit first. A header CRC byte that differs from the CRC of bytes 0 to 14 sets bit 2. A data CRC byte that differs from the CRC of the data bytes sets bit 3.
- R6: A read-modify-write command (code 0111) whose length field is not 8 sets bit 7.
- R7: A verified write (code bits 3 and 2 both set) whose length field is not 4 sets bit 13.
- R8: A length field above MAX_DATA sets bit 6. The checks of R5, R6, R7 and R8 are applied in that order at the header CRC byte.
- R9: A marker that arrives before the packet is complete sets bit 9 (normal end) or bit 11 (error end). An error end in the exact expected position also sets bit 11.
- R10: Data bytes after the expected end, followed by a marker, set bit 10 (normal end) or bit 12 (error end).
- R11: When an unfinished packet sees no character for `tmo_limit` cycles, bit 1 is set and the parser returns to idle. A `tmo_limit` of 0 disables this.
- R12: Each packet records at most one fault. After that fault, characters are dropped up to and including the next marker.
- R13: Status bits stay set until `clr_en` is high together with a 1 in the matching bit of `clr_mask`. Bits whose mask bit is 0 are kept.
- R14: A packet ended by a normal marker in the expected position with no fault raises `pkt_good` for one cycle, in the cycle after the marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A character is present this cycle |
| in_ctrl | input | 1 | 1: the character is an end marker |
| in_data | input | 8 | Data byte; for a marker, bit 0 = error end |
| tmo_limit | input | TMO_W | Idle cycles allowed inside a packet, 0 = off |
| clr_en | input | 1 | Clear strobe for status bits |
| clr_mask | input | 14 | Status bits to clear when `clr_en` is high |
| status | output | 14 | Sticky fault word, bit 0 = any fault |
| pkt_good | output | 1 | One-cycle pulse for an accepted command |

## Verification
Most internal faults show up in the status word one cycle after the offending character, so each case is checked a few cycles after its packet. A header position counter that is off by one shows as a wrong CRC or key fault, or as a wrong early/late flag. A CRC register that is not restarted between header and data fails a data packet that is otherwise correct. A parser left in the drop state shows on the next clean packet, which then gives no `pkt_good` pulse. A timer that is off by a few cycles shows in the timeout window checks.

// File: rtl/rmap_chk_pkg.sv
package rmap_chk_pkg;

   localparam int ST_W   = 14;

   // status bit positions (software decodes these)
   localparam int E_ANY  = 0;
   localparam int E_TMO  = 1;
   localparam int E_HCRC = 2;
   localparam int E_DCRC = 3;
   localparam int E_KEY  = 4;
   localparam int E_CMD  = 5;
   localparam int E_LEN  = 6;
   localparam int E_RMW  = 7;
   localparam int E_LA   = 8;
   localparam int E_EEOP = 9;
   localparam int E_LEOP = 10;
   localparam int E_EEEP = 11;
   localparam int E_LEEP = 12;
   localparam int E_VBUF = 13;

   typedef enum logic [2:0] {
      P_HDR,
      P_DATA,
      P_DCRC,
      P_TAIL,
      P_LATE,
      P_DROP
   } pstate_t;

   // one byte of the reflected CRC-8 (x^8+x^2+x+1), lsb first
   function automatic logic [7:0] crc8_step(input logic [7:0] c, input logic [7:0] b);
      logic [7:0] r;
      r = c ^ b;
      for (int i = 0; i < 8; i++)
         r = r[0] ? ((r >> 1) ^ 8'hE0) : (r >> 1);
      return r;
   endfunction

endpackage

// File: rtl/rmap_crc8_acc.sv
module rmap_crc8_acc
   import rmap_chk_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic              step,
   input  logic [BYTE_W-1:0] din,
   output logic [BYTE_W-1:0] crc_q
);

   generate
      if (BYTE_W != 8) begin : g_bad_w
         $error("rmap_crc8_acc: BYTE_W must be 8");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         crc_q <= '0;
      else if (restart)
         crc_q <= '0;
      else if (step)
         crc_q <= crc8_step(crc_q, din);
   end

   // R5: folding the current remainder into itself leaves zero
   crc_self_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !restart && din == crc_q) |=> (crc_q == '0));

endmodule

// File: rtl/rmap_idle_timer.sv
module rmap_idle_timer #(
   parameter int TMO_W   = 16,
   parameter bit USE_TMO = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic             beat,
   input  logic [TMO_W-1:0] limit,
   output logic             expire
);

   generate
      if (TMO_W < 2) begin : g_bad_w
         $error("rmap_idle_timer: TMO_W too small");
      end

      if (USE_TMO) begin : g_tmo
         logic [TMO_W-1:0] cnt;

         always_comb
            expire = active && !beat && (limit != '0) && (cnt == limit - TMO_W'(1));

         always_ff @(posedge clk) begin
            if (!rst_n)
               cnt <= '0;
            else if (!active || beat || expire)
               cnt <= '0;
            else
               cnt <= cnt + TMO_W'(1);
         end

         // R11: the counter never runs past an enabled limit
         tmo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (limit != '0 && $stable(limit)) |-> (cnt < limit));
      end else begin : g_no_tmo
         always_comb expire = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/rmap_err_status.sv
module rmap_err_status
   import rmap_chk_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic [ST_W-1:0] set_vec,
   input  logic            clr_en,
   input  logic [ST_W-1:0] clr_mask,
   output logic [ST_W-1:0] status
);

   logic [ST_W-1:1] sticky_q;
   logic [ST_W-1:1] wipe;

   always_comb begin
      wipe   = clr_en ? clr_mask[ST_W-1:1] : '0;
      status = {sticky_q, |sticky_q};
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         sticky_q <= '0;
      else
         sticky_q <= (sticky_q & ~wipe) | set_vec[ST_W-1:1];
   end

   generate
      for (genvar k = 1; k < ST_W; k++) begin : g_bit_chk
         // R13
         set_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
            set_vec[k] |=> status[k]);
         // R13
         hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (status[k] && !(clr_en && clr_mask[k])) |=> status[k]);
      end
   endgenerate

   // R1
   summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|set_vec[ST_W-1:1]) |=> status[E_ANY]);

endmodule

// File: rtl/rmap_cmd_validator.sv
module rmap_cmd_validator
   import rmap_chk_pkg::*;
#(
   parameter int          BYTE_W    = 8,
   parameter int          HDR_LEN   = 16,
   parameter int          LEN_W     = 24,
   parameter int          MAX_DATA  = 64,
   parameter int          TMO_W     = 16,
   parameter bit          USE_TMO   = 1'b1,
   parameter logic [7:0]  TARGET_LA = 8'd254,
   parameter logic [7:0]  DEST_KEY  = 8'h20,
   parameter logic [15:0] CMD_MASK  = 16'hFF8C
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_ctrl,
   input  logic [BYTE_W-1:0] in_data,
   input  logic [TMO_W-1:0]  tmo_limit,
   input  logic              clr_en,
   input  logic [ST_W-1:0]   clr_mask,
   output logic [ST_W-1:0]   status,
   output logic              pkt_good
);

   localparam int POS_W   = $clog2(HDR_LEN);
   localparam int POS_LA  = 0;
   localparam int POS_INS = 2;
   localparam int POS_KEY = 3;
   localparam int POS_LEN = HDR_LEN - 1 - (LEN_W / 8);
   localparam int POS_CRC = HDR_LEN - 1;

   generate
      if (BYTE_W != 8) begin : g_bad_byte
         $error("rmap_cmd_validator: BYTE_W must be 8");
      end
      if (HDR_LEN != 16) begin : g_bad_hdr
         $error("rmap_cmd_validator: HDR_LEN must be 16");
      end
      if (LEN_W != 24) begin : g_bad_len
         $error("rmap_cmd_validator: LEN_W must be 24");
      end
      if (MAX_DATA < 8 || MAX_DATA >= (1 << 23)) begin : g_bad_max
         $error("rmap_cmd_validator: MAX_DATA out of range");
      end
   endgenerate

   pstate_t           st, st_n;
   logic [POS_W-1:0]  pos, pos_n;
   logic [LEN_W-1:0]  len_q, len_n;
   logic [LEN_W-1:0]  cnt, cnt_n;
   logic [3:0]        code_q, code_n;
   logic              good_q, good_n;
   logic [ST_W-1:0]   set_vec;
   logic              crc_rst, crc_step;
   logic [7:0]        crc_q;
   logic              tmo_fire;
   logic              active;
   logic              is_rmw, is_vw, has_data;
   logic              eep;

   always_comb begin
      active   = !(st == P_HDR && pos == '0);
      is_rmw   = (code_q == 4'b0111);
      is_vw    = code_q[3] & code_q[2];
      has_data = code_q[3] | is_rmw;
      eep      = in_data[0];
   end

   rmap_crc8_acc #(.BYTE_W(BYTE_W)) u_crc (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (crc_rst),
      .step    (crc_step),
      .din     (in_data),
      .crc_q   (crc_q)
   );

   rmap_idle_timer #(.TMO_W(TMO_W), .USE_TMO(USE_TMO)) u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (active),
      .beat   (in_valid),
      .limit  (tmo_limit),
      .expire (tmo_fire)
   );

   rmap_err_status u_stat (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_vec  (set_vec),
      .clr_en   (clr_en),
      .clr_mask (clr_mask),
      .status   (status)
   );

   always_comb begin
      st_n     = st;
      pos_n    = pos;
      len_n    = len_q;
      cnt_n    = cnt;
      code_n   = code_q;
      good_n   = 1'b0;
      set_vec  = '0;
      crc_rst  = 1'b0;
      crc_step = 1'b0;

      if (tmo_fire) begin
         set_vec[E_TMO] = 1'b1;
         st_n    = P_HDR;
         pos_n   = '0;
         crc_rst = 1'b1;
      end else if (in_valid && in_ctrl) begin
         case (st)
            P_HDR, P_DATA, P_DCRC: begin
               if (eep) set_vec[E_EEEP] = 1'b1;
               else     set_vec[E_EEOP] = 1'b1;
            end
            P_TAIL: begin
               if (eep) set_vec[E_EEEP] = 1'b1;
               else     good_n = 1'b1;
            end
            P_LATE: begin
               if (eep) set_vec[E_LEEP] = 1'b1;
               else     set_vec[E_LEOP] = 1'b1;
            end
            default: ;
         endcase
         st_n    = P_HDR;
         pos_n   = '0;
         crc_rst = 1'b1;
      end else if (in_valid) begin
         case (st)
            P_HDR: begin
               crc_step = 1'b1;
               pos_n    = pos + POS_W'(1);
               if (int'(pos) >= POS_LEN && int'(pos) < POS_CRC)
                  len_n = {len_q[LEN_W-9:0], in_data};
               if (int'(pos) == POS_INS)
                  code_n = in_data[5:2];

               if (int'(pos) == POS_LA && in_data != TARGET_LA) begin
                  set_vec[E_LA] = 1'b1;
                  st_n = P_DROP;
               end else if (int'(pos) == POS_INS &&
                            (!CMD_MASK[in_data[5:2]] || in_data[1:0] != 2'b00)) begin
                  set_vec[E_CMD] = 1'b1;
                  st_n = P_DROP;
               end else if (int'(pos) == POS_KEY && in_data != DEST_KEY) begin
                  set_vec[E_KEY] = 1'b1;
                  st_n = P_DROP;
               end else if (int'(pos) == POS_CRC) begin
                  crc_rst = 1'b1;
                  pos_n   = '0;
                  cnt_n   = '0;
                  if (in_data != crc_q) begin
                     set_vec[E_HCRC] = 1'b1;
                     st_n = P_DROP;
                  end else if (is_rmw && len_q != LEN_W'(8)) begin
                     set_vec[E_RMW] = 1'b1;
                     st_n = P_DROP;
                  end else if (is_vw && len_q != LEN_W'(4)) begin
                     set_vec[E_VBUF] = 1'b1;
                     st_n = P_DROP;
                  end else if (len_q > LEN_W'(MAX_DATA)) begin
                     set_vec[E_LEN] = 1'b1;
                     st_n = P_DROP;
                  end else if (!has_data) begin
                     st_n = P_TAIL;
                  end else if (len_q == '0) begin
                     st_n = P_DCRC;
                  end else begin
                     st_n = P_DATA;
                  end
               end
            end
            P_DATA: begin
               crc_step = 1'b1;
               cnt_n    = cnt + LEN_W'(1);
               if (cnt == len_q - LEN_W'(1))
                  st_n = P_DCRC;
            end
            P_DCRC: begin
               if (in_data != crc_q) begin
                  set_vec[E_DCRC] = 1'b1;
                  st_n = P_DROP;
               end else begin
                  st_n = P_TAIL;
               end
            end
            P_TAIL: st_n = P_LATE;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= P_HDR;
         pos    <= '0;
         len_q  <= '0;
         cnt    <= '0;
         code_q <= '0;
         good_q <= 1'b0;
      end else begin
         st     <= st_n;
         pos    <= pos_n;
         len_q  <= len_n;
         cnt    <= cnt_n;
         code_q <= code_n;
         good_q <= good_n;
      end
   end

   assign pkt_good = good_q;

   // R12
   one_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(set_vec));

   // R14
   good_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_good |-> $past(in_valid && in_ctrl && !in_data[0]));

   // R9
   early_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == P_DATA && in_valid && in_ctrl && !tmo_fire) |=>
         (status[E_EEOP] || status[E_EEEP]));

   // R11
   tmo_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_fire |=> (st == P_HDR && pos == '0 && status[E_TMO]));

endmodule

// File: tb/rmap_cmd_validator_test.sv
module rmap_cmd_validator_test;

   localparam int TMO_W = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ctrl = 1'b0;
   logic [7:0]  in_data = 8'h00;
   logic [TMO_W-1:0] tmo_limit = 16'd20;
   logic        clr_en = 1'b0;
   logic [13:0] clr_mask = '0;
   logic [13:0] status;
   logic        pkt_good;

   always #5 clk = ~clk;

   rmap_cmd_validator uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ctrl(in_ctrl),
      .in_data(in_data), .tmo_limit(tmo_limit), .clr_en(clr_en),
      .clr_mask(clr_mask), .status(status), .pkt_good(pkt_good)
   );

   typedef struct {
      logic [13:0] exp;
      int          good;
      bit          clr;
      string       tag;
   } item_t;

   item_t sbq[$];
   int    n_chk = 0;
   int    n_bad = 0;
   int    good_seen = 0;
   bit    mon_busy = 1'b0;
   bit    done = 1'b0;

   function automatic logic [7:0] ref_crc(input logic [7:0] c, input logic [7:0] b);
      logic [7:0] r;
      r = c ^ b;
      for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ 8'hE0) : (r >> 1);
      return r;
   endfunction

   function automatic logic [13:0] ev(input int k);
      return 14'(1 << k) | 14'd1;
   endfunction

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   always @(negedge clk) if (pkt_good) good_seen++;

   // monitor: pops expected results and compares
   initial begin
      forever begin
         wait (sbq.size() != 0);
         mon_busy = 1'b1;
         repeat (4) @(negedge clk);
         begin
            item_t it;
            it = sbq.pop_front();
            check(it.tag, 32'(status), 32'(it.exp));
            check({it.tag, " good"}, 32'(good_seen), 32'(it.good));
            good_seen = 0;
            if (it.clr) begin
               clr_en = 1'b1; clr_mask = '1;
               @(negedge clk);
               clr_en = 1'b0; clr_mask = '0;
               @(negedge clk);
            end
         end
         mon_busy = 1'b0;
      end
   end

   task automatic put(input logic ctrl, input logic [7:0] b);
      @(negedge clk);
      in_valid = 1'b1; in_ctrl = ctrl; in_data = b;
   endtask

   task automatic idle();
      @(negedge clk);
      in_valid = 1'b0; in_ctrl = 1'b0;
   endtask

   task automatic expect_item(input logic [13:0] exp, input int good, input bit clr, input string tag);
      item_t it;
      it.exp = exp; it.good = good; it.clr = clr; it.tag = tag;
      sbq.push_back(it);
      #1;
      wait (sbq.size() == 0 && !mon_busy);
   endtask

   task automatic send(input logic [7:0] la, input logic [7:0] ins, input logic [7:0] key,
                       input int len, input bit bad_h, input bit bad_d, input int cut,
                       input int extra, input bit eep, input logic [13:0] exp,
                       input int good, input bit clr, input string tag);
      logic [7:0] pk[$];
      logic [7:0] c;
      bit hasd;
      pk = {la, 8'h01, ins, key, 8'hFE, 8'h12, 8'h34, 8'h00,
            8'h40, 8'h00, 8'h10, 8'h00, 8'(len >> 16), 8'(len >> 8), 8'(len)};
      c = 8'h00;
      foreach (pk[i]) c = ref_crc(c, pk[i]);
      pk.push_back(c ^ (bad_h ? 8'h5A : 8'h00));
      hasd = ins[5] || (ins[5:2] == 4'b0111);
      if (hasd) begin
         c = 8'h00;
         for (int i = 0; i < len; i++) begin
            pk.push_back(8'(i * 7 + 3));
            c = ref_crc(c, 8'(i * 7 + 3));
         end
         pk.push_back(c ^ (bad_d ? 8'h81 : 8'h00));
      end
      if (cut >= 0) while (pk.size() > cut) void'(pk.pop_back());
      for (int i = 0; i < extra; i++) pk.push_back(8'hAA);
      foreach (pk[i]) put(1'b0, pk[i]);
      put(1'b1, {7'b0, eep});
      idle();
      expect_item(exp, good, clr, tag);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check("R1 reset status", 32'(status), 32'h0);
      check("R1 reset good", 32'(pkt_good), 32'h0);

      // R14: good write (code 1001), good read (code 0011)
      send(8'd254, 8'h64, 8'h20, 4, 0, 0, -1, 0, 0, 14'h0, 1, 1, "R14 good write");
      send(8'd254, 8'h4C, 8'h20, 8, 0, 0, -1, 0, 0, 14'h0, 1, 1, "R14 good read");
      // R2
      send(8'd16, 8'h64, 8'h20, 4, 0, 0, -1, 0, 0, ev(8), 0, 1, "R2 bad address");
      // R3
      send(8'd254, 8'h64, 8'h21, 4, 0, 0, -1, 0, 0, ev(4), 0, 1, "R3 bad key");
      // R4
      send(8'd254, 8'h40, 8'h20, 0, 0, 0, -1, 0, 0, ev(5), 0, 1, "R4 code 0");
      send(8'd254, 8'h4D, 8'h20, 8, 0, 0, -1, 0, 0, ev(5), 0, 1, "R4 reply length");
      // R5
      send(8'd254, 8'h64, 8'h20, 4, 1, 0, -1, 0, 0, ev(2), 0, 1, "R5 header crc");
      send(8'd254, 8'h64, 8'h20, 6, 0, 1, -1, 0, 0, ev(3), 0, 1, "R5 data crc");
      // R6
      send(8'd254, 8'h5C, 8'h20, 6, 0, 0, -1, 0, 0, ev(7), 0, 1, "R6 rmw len 6");
      send(8'd254, 8'h5C, 8'h20, 8, 0, 0, -1, 0, 0, 14'h0, 1, 1, "R6 rmw len 8");
      // R7: verified write code 1100
      send(8'd254, 8'h70, 8'h20, 2, 0, 0, -1, 0, 0, ev(13), 0, 1, "R7 verify len 2");
      send(8'd254, 8'h70, 8'h20, 4, 0, 0, -1, 0, 0, 14'h0, 1, 1, "R7 verify len 4");
      // R8 and precedence: header crc beats length
      send(8'd254, 8'h64, 8'h20, 100, 0, 0, -1, 0, 0, ev(6), 0, 1, "R8 too long");
      send(8'd254, 8'h5C, 8'h20, 6, 1, 0, -1, 0, 0, ev(2), 0, 1, "R8 order crc first");
      // R9
      send(8'd254, 8'h64, 8'h20, 4, 0, 0, 10, 0, 0, ev(9), 0, 1, "R9 early eop header");
      send(8'd254, 8'h64, 8'h20, 8, 0, 0, 20, 0, 1, ev(11), 0, 1, "R9 early eep data");
      send(8'd254, 8'h64, 8'h20, 4, 0, 0, -1, 0, 1, ev(11), 0, 1, "R9 eep at end");
      // R10
      send(8'd254, 8'h64, 8'h20, 4, 0, 0, -1, 3, 0, ev(10), 0, 1, "R10 late eop");
      send(8'd254, 8'h4C, 8'h20, 8, 0, 0, -1, 2, 1, ev(12), 0, 1, "R10 late eep");
      // R12: bad address and bad key, only the first is kept
      send(8'd16, 8'h64, 8'h21, 4, 1, 0, -1, 0, 0, ev(8), 0, 1, "R12 first fault");

      // R11: timeout inside a packet
      put(1'b0, 8'd254); put(1'b0, 8'h01); put(1'b0, 8'h64);
      idle();
      repeat (14) @(negedge clk);
      check("R11 no early timeout", 32'(status), 32'h0);
      repeat (12) @(negedge clk);
      expect_item(ev(1), 0, 1, "R11 timeout");
      send(8'd254, 8'h64, 8'h20, 4, 0, 0, -1, 0, 0, 14'h0, 1, 1, "R11 idle after timeout");

      // R13: sticky accumulation and selective clear
      send(8'd16, 8'h64, 8'h20, 4, 0, 0, -1, 0, 0, ev(8), 0, 0, "R13 first");
      send(8'd254, 8'h64, 8'h21, 4, 0, 0, -1, 0, 0, ev(8) | ev(4), 0, 0, "R13 sticky");
      @(negedge clk);
      clr_en = 1'b1; clr_mask = 14'h0100;
      @(negedge clk);
      clr_en = 1'b0; clr_mask = '0;
      @(negedge clk);
      check("R13 partial clear", 32'(status), 32'(ev(4)));
      expect_item(ev(4), 0, 1, "R13 before full clear");
      @(negedge clk);
      check("R13 full clear", 32'(status), 32'h0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got hang expected completion");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

endmodule